// File: doc/BRIEF.md
# March C- Memory Self-Test Controller

This block is a built-in self-test sequencer for a word-wide, single-port synchronous memory laid out as a grid of rows and columns. A start pulse makes it walk every word of the grid through the six March C- elements. It drives one memory operation per cycle: the address, the write enable and a background word of all zeros or all ones. Every read result is checked against the value that element expects. The first mismatch is recorded together with its row, column, element number and the data read. A sticky fail flag goes up, and the test still runs to its end.

A run-time pin selects the scan order. In row-fast order the row index steps first and the column moves on only when the row wraps. In column-fast order the two roles are swapped. Ascending elements start at row 0, column 0. Descending elements start at the highest row and column and visit the same cells in exactly the reverse order. The memory side has no back-pressure: the memory must accept every request in the cycle it is presented, and it must return read data in the next cycle.

Top module: `mbist_marchc`

## Requirements
- R1: A high `start_i` while `busy_o` is low begins a test, and `busy_o` rises in the next cycle. A `start_i` pulse while `busy_o` is high has no effect on the operation stream, its length or the result.
- R2: The operations follow March C- in order. Element 0 writes 0. Elements 1 and 2 are ascending: element 1 reads 0 then writes 1, and element 2 reads 1 then writes 0. Elements 3, 4 and 5 are descending: element 3 reads 0 then writes 1, element 4 reads 1 then writes 0, and element 5 reads 0. In elements 1 to 4 the read and the write of one cell come in consecutive cycles. Value 0 is the word of all zero bits and value 1 is the word of all one bits.
- R3: A test issues exactly 10·n memory operations, where n = 2^(ROW_BITS+COL_BITS). They come in consecutive cycles, with `mem_en_o` high for each.
- R4: With `scan_col_first_i`=0 (sampled at start), the row address steps first and the column steps when the row wraps. With 1, the column steps first and the row steps when the column wraps.
- R5: Descending elements begin at row 2^ROW_BITS-1 and column 2^COL_BITS-1, and visit the cells in the exact reverse of the ascending order.
- R6: Read data on `mem_rdata_i` is compared in the cycle after the read is issued. Any bit that differs from the expected background word sets `fail_o`.
- R7: On the first mismatch of a test, `fail_row_o`, `fail_col_o`, `fail_elem_o` (element number 0 to 5 as listed in R2) and `fail_data_o` are captured. Later mismatches leave them unchanged. The test still issues all 10·n operations.
- R8: `done_o` is high for exactly one cycle. That cycle is two cycles after the last read was issued, i.e. the 10·n+2nd cycle after the start edge. In that cycle `busy_o` is low and the fail outputs are final.
- R9: After reset `busy_o`, `done_o`, `fail_o` and `mem_en_o` are low. An accepted start clears `fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| scan_col_first_i | input | 1 | 0: row-fast scan, 1: column-fast scan |
| mem_en_o | output | 1 | Memory operation valid this cycle |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_row_o | output | ROW_BITS | Row address |
| mem_col_o | output | COL_BITS | Column address |
| mem_wdata_o | output | DATA_W | Write background word |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after a read |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_row_o | output | ROW_BITS | Row of first mismatch |
| fail_col_o | output | COL_BITS | Column of first mismatch |
| fail_elem_o | output | 3 | Element of first mismatch |
| fail_data_o | output | DATA_W | Data read at first mismatch |

## Verification
In elements 1 to 4, the comparison of a cell's read data and the write to that same cell fall in the same cycle. A stuck cell in those elements therefore has its bad read judged while the sequencer has already moved on to the write. The bench injects stuck-at-0 and stuck-at-1 bits and checks that the captured address is the cell that was read, not the next one. It also checks the element number, and that the captured data is the faulty word. With two faulty cells, the first capture must follow the scan order, and the bench confirms that the second fault never overwrites it.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int ELEM_W = 3;
  typedef logic [ELEM_W-1:0] elem_t;
  localparam elem_t ELEM_FIRST = elem_t'(0);
  localparam elem_t ELEM_LAST  = elem_t'(5);
  localparam elem_t ELEM_DESC0 = elem_t'(3);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} seq_state_e;

  function automatic logic elem_reads(elem_t e);
    return e != ELEM_FIRST;
  endfunction

  function automatic logic elem_writes(elem_t e);
    return e != ELEM_LAST;
  endfunction

  function automatic logic elem_desc(elem_t e);
    return e >= ELEM_DESC0;
  endfunction

  // background expected by the read of an element
  function automatic logic elem_rd_val(elem_t e);
    return (e == elem_t'(2)) || (e == elem_t'(4));
  endfunction

  // background written by an element
  function automatic logic elem_wr_val(elem_t e);
    return (e == elem_t'(1)) || (e == elem_t'(3));
  endfunction
endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                load_desc_i,
  input  logic                step_i,
  input  logic                desc_i,
  input  logic                col_first_i,
  output logic [ROW_BITS-1:0] row_o,
  output logic [COL_BITS-1:0] col_o,
  output logic                last_o
);
  localparam logic [ROW_BITS-1:0] ROW_MAX = '1;
  localparam logic [COL_BITS-1:0] COL_MAX = '1;

  logic [ROW_BITS-1:0] row_q, row_nxt;
  logic [COL_BITS-1:0] col_q, col_nxt;
  logic                row_end, col_end;

  always_comb begin
    row_end = desc_i ? (row_q == '0) : (row_q == ROW_MAX);
    col_end = desc_i ? (col_q == '0) : (col_q == COL_MAX);
    // modular arithmetic wraps to the start value of the same direction
    row_nxt = desc_i ? row_q - 1'b1 : row_q + 1'b1;
    col_nxt = desc_i ? col_q - 1'b1 : col_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load_i) begin
      row_q <= load_desc_i ? ROW_MAX : '0;
      col_q <= load_desc_i ? COL_MAX : '0;
    end else if (step_i) begin
      if (col_first_i) begin
        col_q <= col_nxt;
        if (col_end) row_q <= row_nxt;
      end else begin
        row_q <= row_nxt;
        if (row_end) col_q <= col_nxt;
      end
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign last_o = row_end && col_end;
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  scan_col_first_i,
  input  logic  last_i,
  output logic  ag_load_o,
  output logic  ag_load_desc_o,
  output logic  ag_step_o,
  output logic  ag_desc_o,
  output logic  col_first_o,
  output logic  mem_en_o,
  output logic  mem_we_o,
  output logic  wr_bit_o,
  output logic  rd_issue_o,
  output logic  rd_exp_o,
  output elem_t elem_o,
  output logic  clear_o,
  output logic  busy_o,
  output logic  done_o
);
  seq_state_e state_q;
  elem_t      elem_q;
  logic       phase_q;   // 1: write half of a read-then-write pair
  logic       col_first_q;
  logic       done_q;

  logic run, accept, is_rd, is_wr, step, elem_end;

  always_comb begin
    run      = (state_q == ST_RUN);
    accept   = (state_q == ST_IDLE) && start_i;
    is_rd    = run && elem_reads(elem_q) && !phase_q;
    is_wr    = run && !is_rd;
    step     = is_wr || (is_rd && !elem_writes(elem_q));
    elem_end = step && last_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      elem_q      <= ELEM_FIRST;
      phase_q     <= 1'b0;
      col_first_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q     <= ST_RUN;
          elem_q      <= ELEM_FIRST;
          phase_q     <= 1'b0;
          col_first_q <= scan_col_first_i;
        end
        ST_RUN: begin
          if (is_rd && elem_writes(elem_q)) phase_q <= 1'b1;
          if (step) begin
            phase_q <= 1'b0;
            if (last_i) begin
              if (elem_q == ELEM_LAST) state_q <= ST_DRAIN;
              else                     elem_q  <= elem_q + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ag_load_o      = accept || (elem_end && (elem_q != ELEM_LAST));
  assign ag_load_desc_o = accept ? 1'b0 : elem_desc(elem_q + 1'b1);
  assign ag_step_o      = step && !last_i;
  assign ag_desc_o      = elem_desc(elem_q);
  assign col_first_o    = col_first_q;
  assign mem_en_o       = run;
  assign mem_we_o       = is_wr;
  assign wr_bit_o       = elem_wr_val(elem_q);
  assign rd_issue_o     = is_rd;
  assign rd_exp_o       = elem_rd_val(elem_q);
  assign elem_o         = elem_q;
  assign clear_o        = accept;
  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = done_q;
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
  import mbist_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                rd_issue_i,
  input  logic                rd_exp_i,
  input  logic [ROW_BITS-1:0] row_i,
  input  logic [COL_BITS-1:0] col_i,
  input  elem_t               elem_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic                fail_o,
  output logic [ROW_BITS-1:0] fail_row_o,
  output logic [COL_BITS-1:0] fail_col_o,
  output elem_t               fail_elem_o,
  output logic [DATA_W-1:0]   fail_data_o
);
  // read in flight: context of the read issued last cycle
  logic                pend_q, exp_q;
  logic [ROW_BITS-1:0] prow_q;
  logic [COL_BITS-1:0] pcol_q;
  elem_t               pelem_q;
  logic                miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      exp_q   <= 1'b0;
      prow_q  <= '0;
      pcol_q  <= '0;
      pelem_q <= '0;
    end else begin
      pend_q <= rd_issue_i;
      if (rd_issue_i) begin
        exp_q   <= rd_exp_i;
        prow_q  <= row_i;
        pcol_q  <= col_i;
        pelem_q <= elem_i;
      end
    end
  end

  assign miss = pend_q && (rdata_i != {DATA_W{exp_q}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o      <= 1'b0;
      fail_row_o  <= '0;
      fail_col_o  <= '0;
      fail_elem_o <= '0;
      fail_data_o <= '0;
    end else if (clear_i) begin
      fail_o <= 1'b0;
    end else if (miss && !fail_o) begin
      fail_o      <= 1'b1;
      fail_row_o  <= prow_q;
      fail_col_o  <= pcol_q;
      fail_elem_o <= pelem_q;
      fail_data_o <= rdata_i;
    end
  end
endmodule

// File: rtl/mbist_marchc.sv
module mbist_marchc
  import mbist_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                scan_col_first_i,
  output logic                mem_en_o,
  output logic                mem_we_o,
  output logic [ROW_BITS-1:0] mem_row_o,
  output logic [COL_BITS-1:0] mem_col_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o,
  output logic [ROW_BITS-1:0] fail_row_o,
  output logic [COL_BITS-1:0] fail_col_o,
  output logic [2:0]          fail_elem_o,
  output logic [DATA_W-1:0]   fail_data_o
);
  logic  ag_load, ag_load_desc, ag_step, ag_desc, col_first, last;
  logic  wr_bit, rd_issue, rd_exp, clear;
  elem_t elem, fail_elem;

  mbist_addr_gen #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_addr (
    .clk_i, .rst_ni,
    .load_i(ag_load), .load_desc_i(ag_load_desc), .step_i(ag_step),
    .desc_i(ag_desc), .col_first_i(col_first),
    .row_o(mem_row_o), .col_o(mem_col_o), .last_o(last)
  );

  mbist_seq u_seq (
    .clk_i, .rst_ni, .start_i, .scan_col_first_i, .last_i(last),
    .ag_load_o(ag_load), .ag_load_desc_o(ag_load_desc), .ag_step_o(ag_step),
    .ag_desc_o(ag_desc), .col_first_o(col_first),
    .mem_en_o, .mem_we_o, .wr_bit_o(wr_bit),
    .rd_issue_o(rd_issue), .rd_exp_o(rd_exp), .elem_o(elem),
    .clear_o(clear), .busy_o, .done_o
  );

  mbist_cmp #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_cmp (
    .clk_i, .rst_ni, .clear_i(clear),
    .rd_issue_i(rd_issue), .rd_exp_i(rd_exp),
    .row_i(mem_row_o), .col_i(mem_col_o), .elem_i(elem),
    .rdata_i(mem_rdata_i),
    .fail_o, .fail_row_o, .fail_col_o, .fail_elem_o(fail_elem), .fail_data_o
  );

  assign mem_wdata_o = {DATA_W{wr_bit}};
  assign fail_elem_o = fail_elem;
endmodule

// File: rtl/mbist_marchc_chk.sv
module mbist_marchc_chk #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 2,
  parameter int DATA_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                mem_en_o,
  input logic                mem_we_o,
  input logic [DATA_W-1:0]   mem_wdata_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                fail_o,
  input logic [ROW_BITS-1:0] fail_row_o,
  input logic [COL_BITS-1:0] fail_col_o,
  input logic [2:0]          fail_elem_o
);
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R3
  op_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> busy_o);
  // R2
  wdata_bg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && mem_we_o) |-> (mem_wdata_o == '0 || mem_wdata_o == '1));
  // R1
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R7
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && busy_o) |=> fail_o);
  // R7
  capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && busy_o) |=> ($stable(fail_row_o) && $stable(fail_col_o) && $stable(fail_elem_o)));
endmodule

bind mbist_marchc mbist_marchc_chk #(
  .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
  .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
  .fail_row_o(fail_row_o), .fail_col_o(fail_col_o), .fail_elem_o(fail_elem_o)
);

// File: tb/test_mbist_marchc.sv
`timescale 1ns/1ps
module test_mbist_marchc;
  localparam int RB = 3, CB = 2, W = 8;
  localparam int NR = 1 << RB, NC = 1 << CB, N = NR * NC, OPS = 10 * N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, colf = 1'b0;
  logic mem_en, mem_we, busy, done, fail;
  logic [RB-1:0] mem_row, fail_row;
  logic [CB-1:0] mem_col, fail_col;
  logic [2:0] fail_elem;
  logic [W-1:0] wdata, rdata, fail_data;

  always #4 clk = ~clk;   // 125 MHz

  mbist_marchc #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(W)) i_mbist_marchc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scan_col_first_i(colf),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_row_o(mem_row), .mem_col_o(mem_col),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_row_o(fail_row), .fail_col_o(fail_col),
    .fail_elem_o(fail_elem), .fail_data_o(fail_data)
  );

  // fault kinds: 0 none, 1 stuck-at-0 bit, 2 stuck-at-1 bit
  typedef struct packed {
    logic cf; logic [1:0] k1; logic [2:0] r1; logic [1:0] c1;
    logic [1:0] k2; logic [2:0] r2; logic [1:0] c2; logic [2:0] b;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 3'd5, 2'd2, 2'd0, 3'd0, 2'd0, 3'd3},  // sa0 row-fast
    '{1'b1, 2'd0, 3'd0, 2'd0, 2'd0, 3'd0, 2'd0, 3'd0},  // clean col-fast
    '{1'b1, 2'd2, 3'd2, 2'd1, 2'd0, 3'd0, 2'd0, 3'd0},  // sa1 col-fast
    '{1'b0, 2'd2, 3'd0, 2'd1, 2'd2, 3'd1, 2'd0, 3'd7},  // two sa1 row-fast
    '{1'b1, 2'd2, 3'd0, 2'd1, 2'd2, 3'd1, 2'd0, 3'd7},  // two sa1 col-fast
    '{1'b0, 2'd1, 3'd0, 2'd0, 2'd2, 3'd7, 2'd3, 3'd5},  // sa0 + sa1
    '{1'b0, 2'd0, 3'd0, 2'd0, 2'd0, 3'd0, 2'd0, 3'd0}   // clean row-fast
  };

  vec_t cur;
  int total = 0, bad = 0;

  function automatic logic [W-1:0] faulty(logic [W-1:0] d, int r, int c);
    logic [W-1:0] o = d;
    if (cur.k1 != 0 && r == int'(cur.r1) && c == int'(cur.c1)) o[cur.b] = (cur.k1 == 2);
    if (cur.k2 != 0 && r == int'(cur.r2) && c == int'(cur.c2)) o[cur.b] = (cur.k2 == 2);
    return o;
  endfunction

  // memory under test: synchronous single port, one-cycle read
  logic [W-1:0] ram [N];
  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) ram[int'(mem_row)*NC + int'(mem_col)] <= faulty(wdata, int'(mem_row), int'(mem_col));
      else rdata <= faulty(ram[int'(mem_row)*NC + int'(mem_col)], int'(mem_row), int'(mem_col));
    end

  // reference model of the expected stream and first failure
  logic e_we [OPS];
  int e_row [OPS], e_col [OPS];
  logic [W-1:0] e_wd [OPS];
  logic [W-1:0] mdl [N];
  logic x_fail; int x_row, x_col, x_elem; logic [W-1:0] x_data;

  task automatic build(input logic cf);
    int k = 0;
    x_fail = 1'b0; x_row = 0; x_col = 0; x_elem = 0; x_data = '0;
    for (int e = 0; e < 6; e++)
      for (int s = 0; s < N; s++) begin
        int idx, r, c; logic [W-1:0] v;
        idx = (e >= 3) ? N - 1 - s : s;
        if (cf) begin c = idx % NC; r = idx / NC; end
        else    begin r = idx % NR; c = idx / NR; end
        if (e != 0) begin
          v = faulty(mdl[r*NC+c], r, c);
          if (v != ((e == 2 || e == 4) ? {W{1'b1}} : {W{1'b0}}) && !x_fail) begin
            x_fail = 1'b1; x_row = r; x_col = c; x_elem = e; x_data = v;
          end
          e_we[k] = 1'b0; e_row[k] = r; e_col[k] = c; e_wd[k] = '0; k++;
        end
        if (e != 5) begin
          v = (e == 1 || e == 3) ? {W{1'b1}} : {W{1'b0}};
          mdl[r*NC+c] = faulty(v, r, c);
          e_we[k] = 1'b1; e_row[k] = r; e_col[k] = c; e_wd[k] = v; k++;
        end
      end
  endtask

  task automatic chk(input logic ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit mid_start);
    int cyc = 0, opi = 0, seq_bad = 0, done_at = -1;
    cur = v; colf = v.cf;
    build(v.cf);
    @(negedge clk); start = 1'b1;
    while (done_at < 0 && cyc < 2000) begin
      @(negedge clk); cyc++;
      start = mid_start && (cyc == 50);
      if (mem_en) begin
        if (opi >= OPS || mem_we != e_we[opi] || int'(mem_row) != e_row[opi] ||
            int'(mem_col) != e_col[opi] || (mem_we && wdata != e_wd[opi])) seq_bad++;
        opi++;
      end
      if (done) done_at = cyc;
    end
    chk(opi == OPS, "R3 operation count", opi, OPS);
    chk(seq_bad == 0, "R2/R4/R5 op order (R2 R4 R5)", seq_bad, 0);
    chk(done_at == OPS + 2, "R8 done cycle", done_at, OPS + 2);
    chk(!busy, "R8 busy low at done", busy, 0);
    chk(fail == x_fail, "R6 fail flag", fail, x_fail);
    if (x_fail) begin
      chk(int'(fail_row) == x_row, "R7 fail row", fail_row, x_row);
      chk(int'(fail_col) == x_col, "R7 fail col", fail_col, x_col);
      chk(int'(fail_elem) == x_elem, "R7 fail element", fail_elem, x_elem);
      chk(fail_data == x_data, "R7 fail data", fail_data, x_data);
    end else
      chk(!fail, "R9 fail cleared by new start", fail, 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    chk(!mem_en && !busy, "R8 idle after done", {mem_en, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !fail && !mem_en, "R9 reset state",
        {busy, done, fail, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_en, "R9 idle without start", {busy, mem_en}, 0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
    // R1: start while busy must not disturb a faulty or a clean run
    run_vec(VECS[0], 1'b1);
    run_vec(VECS[6], 1'b1);
    // R1: start accepted from idle raises busy next cycle
    cur = VECS[6]; colf = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && mem_en, "R1 busy after start", {busy, mem_en}, 3);
    while (!done) @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule